// File: doc/BRIEF.md
# Byte-Parallel Binary BCH Syndrome Calculator

This block is the input stage of a binary BCH decoder for page-sized flash sectors. A received codeword arrives one byte per clock. It carries K data bytes followed by R parity bytes, and the most significant bit of each byte is sent first. For every selected odd index i = 1, 3, …, 2t−1 the block evaluates the received polynomial at α^i in GF(2^13). The even-indexed syndromes are left out because a binary code gives them as squares of the odd ones. Each accumulator takes in a whole byte per clock. Seen from outside, the stage therefore behaves like a symbol-wide Reed-Solomon syndrome stage.

A start strobe selects the correction strength t and the data length K, clears all accumulators and opens a codeword. Bytes are accepted while `in_valid` is high. After the last byte of the selected length, the block raises `done` for one cycle. The syndromes, and a flag that is true when all of them are zero, then stay on the outputs until the next start.

Control is a three-state machine. `ST_IDLE` waits for `start` and moves to `ST_RUN`. `ST_RUN` accepts bytes. When the final byte is accepted it moves to `ST_REPORT`, and a new `start` keeps it in `ST_RUN` with fresh state. `ST_REPORT` lasts one cycle and drives `done`. It then returns to `ST_IDLE`, or goes to `ST_RUN` if `start` is high.

Top module: `bch_byte_syndrome`

## Requirements
- R1: After reset `done` is 0, every syndrome slot is 0 and `no_err` is 1.
- R2: A cycle with `start` high clears every slot and latches the mode. The t code on `mode_t` maps 0→7, 1→8, 2→14, 3→15, 4→17, and 5, 6 or 7→18. The K code on `mode_k` maps 0→514, 1→515, and 2 or 3→516. Inputs on `mode_t` and `mode_k` are ignored outside a start cycle. A byte offered in the same cycle as `start` is not taken.
- R3: The codeword is K+R bytes, where R is 12, 14, 24, 26, 28 or 30 for t = 7, 8, 14, 15, 17 or 18. `done` is high for exactly the one cycle after the clock that accepts the last byte.
- R4: Slot j of `synd` (bits 13j+12..13j, for j = 0..17) holds r(α^(2j+1)). Here r(x) has the first byte's bit 7 as the coefficient of x^(8N−1) and the last byte's bit 0 as the coefficient of x^0. α is a root of x^13+x^4+x^3+x+1.
- R5: A received word that is a multiple of the code's generator gives all-zero slots and `no_err` = 1.
- R6: A codeword with 1 to t flipped bits gives `no_err` = 0.
- R7: Slots j ≥ t read as zero.
- R8: Cycles with `in_valid` low neither advance the count nor change a slot. Bytes offered while no codeword is open are ignored.
- R9: A `start` in the middle of a codeword discards the partial word. No `done` is produced for it.
- R10: Slots and `no_err` hold their values from `done` until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a codeword, clears slots, latches mode |
| mode_t | input | 3 | Correction-strength code |
| mode_k | input | 2 | Data-length code |
| in_valid | input | 1 | `in_byte` carries a codeword byte this cycle |
| in_byte | input | 8 | Received byte, bit 7 first in polynomial order |
| done | output | 1 | One-cycle pulse after the final byte |
| no_err | output | 1 | All syndrome slots are zero |
| synd | output | 234 | Eighteen 13-bit syndrome slots |

## Verification
The hardest state to reach from the ports is a nonzero-length word whose syndromes are all zero. A random byte stream almost never gets there. To produce one, the bench builds the generator itself as the product of the minimal polynomials of α, α^3, … and multiplies random messages by it. Flipping chosen bit positions in such a word then gives syndromes that a slow bit-at-a-time evaluation can check. The bench also reaches a restart halfway through a word, and a word delivered with random idle gaps, by driving `start` and `in_valid` directly.

// File: rtl/bchs_pkg.sv
package bchs_pkg;
    localparam int GF_M    = 13;
    localparam logic [GF_M-1:0] GF_TAPS = 13'h001B;
    localparam int SYN_MAX = 18;
    localparam int BYTE_W  = 8;
    localparam int LEN_MAX = 546;
    localparam int LEN_W   = $clog2(LEN_MAX);
    localparam int T_W     = $clog2(SYN_MAX + 1);

    typedef logic [GF_M-1:0] gf_t;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_REPORT} st_e;

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t p = '0;
        gf_t x = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) p ^= x;
            x = x[GF_M-1] ? ((x << 1) ^ GF_TAPS) : (x << 1);
        end
        return p;
    endfunction

    function automatic gf_t gf_apow(int e);
        gf_t x = gf_t'(1);
        for (int k = 0; k < e; k++)
            x = x[GF_M-1] ? ((x << 1) ^ GF_TAPS) : (x << 1);
        return x;
    endfunction

    function automatic int t_of(logic [2:0] code);
        case (code)
            3'd0:    return 7;
            3'd1:    return 8;
            3'd2:    return 14;
            3'd3:    return 15;
            3'd4:    return 17;
            default: return 18;
        endcase
    endfunction

    function automatic int par_of(logic [2:0] code);
        case (code)
            3'd0:    return 12;
            3'd1:    return 14;
            3'd2:    return 24;
            3'd3:    return 26;
            3'd4:    return 28;
            default: return 30;
        endcase
    endfunction

    function automatic int data_of(logic [1:0] code);
        case (code)
            2'd0:    return 514;
            2'd1:    return 515;
            default: return 516;
        endcase
    endfunction
endpackage

// File: rtl/bchs_ctrl.sv
module bchs_ctrl
    import bchs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode_t,
    input  logic [1:0]     mode_k,
    input  logic           in_valid,
    output logic           clr,
    output logic           upd,
    output logic [T_W-1:0] t_act,
    output logic           done
);
    st_e              st_q, st_d;
    logic [LEN_W-1:0] cnt_q, last_q;
    logic             last_byte;

    assign last_byte = (st_q == ST_RUN) && in_valid && !start && (cnt_q == last_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = start ? ST_RUN : ST_IDLE;
            ST_RUN:    st_d = start ? ST_RUN : (last_byte ? ST_REPORT : ST_RUN);
            ST_REPORT: st_d = start ? ST_RUN : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
            t_act  <= T_W'(t_of(3'd0));
        end else if (start) begin
            cnt_q  <= '0;
            last_q <= LEN_W'(data_of(mode_k) + par_of(mode_t) - 1);
            t_act  <= T_W'(t_of(mode_t));
        end else if (upd) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        clr  = start;
        upd  = (st_q == ST_RUN) && in_valid && !start;
        done = (st_q == ST_REPORT);
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(upd));
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q <= last_q));
endmodule

// File: rtl/bchs_cell.sv
module bchs_cell
    import bchs_pkg::*;
#(
    parameter int EXP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic              act,
    input  logic [BYTE_W-1:0] byte_in,
    output gf_t               acc
);
    localparam gf_t STEP = gf_apow(BYTE_W * EXP);

    gf_t term [BYTE_W];
    gf_t fold, nxt;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        localparam gf_t PW = gf_apow(b * EXP);
        assign term[b] = byte_in[b] ? PW : '0;
    end

    always_comb begin
        fold = '0;
        for (int k = 0; k < BYTE_W; k++) fold ^= term[k];
        nxt = gf_mul(acc, STEP) ^ fold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          acc <= '0;
        else if (clr)        acc <= '0;
        else if (upd && act) acc <= nxt;
    end

    a_r7_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (acc == '0));
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(acc));
endmodule

// File: rtl/bch_byte_syndrome.sv
module bch_byte_syndrome
    import bchs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [2:0]                mode_t,
    input  logic [1:0]                mode_k,
    input  logic                      in_valid,
    input  logic [BYTE_W-1:0]         in_byte,
    output logic                      done,
    output logic                      no_err,
    output logic [SYN_MAX*GF_M-1:0]   synd
);
    logic           clr, upd;
    logic [T_W-1:0] t_act;

    bchs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_t(mode_t),
        .mode_k(mode_k), .in_valid(in_valid), .clr(clr), .upd(upd),
        .t_act(t_act), .done(done)
    );

    for (genvar j = 0; j < SYN_MAX; j++) begin : g_syn
        logic act_j;
        assign act_j = (T_W'(j) < t_act);
        bchs_cell #(.EXP(2 * j + 1)) u_cell (
            .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .act(act_j),
            .byte_in(in_byte), .acc(synd[j*GF_M +: GF_M])
        );
    end

    assign no_err = ~|synd;

    a_r10_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(synd));
endmodule

// File: tb/tb_bch_byte_syndrome.sv
module tb_bch_byte_syndrome;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   mode_t = '0;
    logic [1:0]   mode_k = '0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = '0;
    logic         done, no_err;
    logic [233:0] synd;

    int total = 0;
    int bad = 0;

    bit          cw [0:4367];
    bit          flipped [0:4367];
    bit          gp [0:255];
    int          gdeg;
    logic [12:0] exp_s [0:17];

    always #4 clk = ~clk;

    bch_byte_syndrome dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_t(mode_t), .mode_k(mode_k),
        .in_valid(in_valid), .in_byte(in_byte), .done(done), .no_err(no_err),
        .synd(synd)
    );

    function automatic logic [12:0] fm(logic [12:0] a, logic [12:0] b);
        logic [12:0] p = '0;
        for (int k = 12; k >= 0; k--) begin
            p = p[12] ? ((p << 1) ^ 13'h001B) : (p << 1);
            if (b[k]) p ^= a;
        end
        return p;
    endfunction

    function automatic logic [12:0] ap(int e);
        logic [12:0] r = 13'd1;
        for (int k = 0; k < e; k++) r = fm(r, 13'd2);
        return r;
    endfunction

    function automatic int tval(int c);
        int tab [0:7] = '{7, 8, 14, 15, 17, 18, 18, 18};
        return tab[c];
    endfunction

    function automatic int nbytes(int tc, int kc);
        int rt [0:7] = '{12, 14, 24, 26, 28, 30, 30, 30};
        int kt [0:3] = '{514, 515, 516, 516};
        return rt[tc] + kt[kc];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic make_gen(input int t);
        logic [12:0] mp [0:13];
        logic [12:0] root;
        bit tmp [0:255];
        int d;
        for (int n = 0; n < 256; n++) gp[n] = 0;
        gp[0] = 1;
        gdeg = 0;
        for (int j = 1; j <= t; j++) begin
            for (int n = 0; n < 14; n++) mp[n] = '0;
            mp[0] = 13'd1;
            d = 0;
            root = ap(2 * j - 1);
            for (int k = 0; k < 13; k++) begin
                for (int n = d + 1; n >= 1; n--) mp[n] = mp[n-1] ^ fm(mp[n], root);
                mp[0] = fm(mp[0], root);
                d++;
                root = fm(root, root);
            end
            for (int n = 0; n < 256; n++) tmp[n] = 0;
            for (int a = 0; a <= gdeg; a++)
                if (gp[a]) for (int b = 0; b <= 13; b++) tmp[a+b] ^= mp[b][0];
            gdeg += 13;
            for (int n = 0; n < 256; n++) gp[n] = tmp[n];
        end
    endtask

    task automatic encode(input int nb);
        int len = nb * 8;
        for (int n = 0; n < 4368; n++) begin cw[n] = 0; flipped[n] = 0; end
        for (int a = 0; a < len - gdeg; a++)
            if ($urandom() % 2 == 1)
                for (int b = 0; b <= gdeg; b++) cw[a+b] ^= gp[b];
    endtask

    task automatic inject(input int nb, input int nerr);
        int pos;
        for (int e = 0; e < nerr; e++) begin
            pos = $urandom_range(0, nb * 8 - 1);
            while (flipped[pos]) pos = $urandom_range(0, nb * 8 - 1);
            flipped[pos] = 1;
            cw[pos] ^= 1'b1;
        end
    endtask

    task automatic calc_ref(input int t, input int nb);
        logic [12:0] s, beta;
        for (int j = 0; j < 18; j++) begin
            s = '0;
            if (j < t) begin
                beta = ap(2 * j + 1);
                for (int d = nb * 8 - 1; d >= 0; d--) s = fm(s, beta) ^ {12'd0, cw[d]};
            end
            exp_s[j] = s;
        end
    endtask

    function automatic logic [7:0] byte_at(int nb, int b);
        logic [7:0] v;
        for (int q = 0; q < 8; q++) v[q] = cw[nb * 8 - 8 * b - 8 + q];
        return v;
    endfunction

    task automatic do_start(input int tc, input int kc);
        @(negedge clk);
        start = 1'b1; mode_t = 3'(tc); mode_k = 2'(kc);
        in_valid = 1'b1; in_byte = 8'($urandom());
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        mode_t = 3'($urandom()); mode_k = 2'($urandom());
    endtask

    task automatic send_word(input int nb, input bit gaps);
        for (int b = 0; b < nb; b++) begin
            if (gaps && ($urandom() % 3 == 0)) begin
                in_valid = 1'b0; in_byte = 8'($urandom());
                @(negedge clk);
            end
            check(done == 1'b0, "R3 done early", 32'(done), 0);
            in_valid = 1'b1; in_byte = byte_at(nb, b);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(done == 1'b1, "R3 done after last byte", 32'(done), 1);
    endtask

    task automatic check_syn(input string req);
        for (int j = 0; j < 18; j++)
            check(synd[j*13 +: 13] == exp_s[j], req, 32'(synd[j*13 +: 13]), 32'(exp_s[j]));
    endtask

    task automatic done_low_next();
        @(negedge clk);
        check(done == 1'b0, "R3 done one cycle", 32'(done), 0);
    endtask

    task automatic test_reset();
        check(done == 1'b0, "R1 done", 32'(done), 0);
        check(synd == '0, "R1 synd", 32'(synd[31:0]), 0);
        check(no_err == 1'b1, "R1 no_err", 32'(no_err), 1);
    endtask

    task automatic test_clean(input int tc, input int kc);
        int nb = nbytes(tc, kc);
        make_gen(tval(tc));
        encode(nb);
        calc_ref(tval(tc), nb);
        do_start(tc, kc);
        send_word(nb, 1'b0);
        for (int j = 0; j < 18; j++)
            check(exp_s[j] == '0, "R5 bench codeword", 32'(exp_s[j]), 0);
        check_syn("R5 R7 clean syndromes");
        check(no_err == 1'b1, "R5 no_err", 32'(no_err), 1);
        done_low_next();
    endtask

    task automatic test_errors(input int tc, input int kc, input int nerr, input bit gaps);
        int nb = nbytes(tc, kc);
        make_gen(tval(tc));
        encode(nb);
        inject(nb, nerr);
        calc_ref(tval(tc), nb);
        do_start(tc, kc);
        send_word(nb, gaps);
        check_syn(gaps ? "R8 R4 stalled syndromes" : "R4 R7 syndromes");
        check(no_err == 1'b0, "R6 no_err", 32'(no_err), 0);
        done_low_next();
    endtask

    task automatic test_hold();
        for (int c = 0; c < 6; c++) begin
            in_valid = 1'b1; in_byte = 8'($urandom());
            mode_t = 3'($urandom());
            @(negedge clk);
            check(done == 1'b0, "R8 idle bytes no done", 32'(done), 0);
        end
        in_valid = 1'b0;
        check_syn("R10 R8 hold after done");
        check(no_err == 1'b0, "R10 no_err held", 32'(no_err), 0);
    endtask

    task automatic test_restart();
        int nb = nbytes(1, 1);
        do_start(4, 2);
        for (int b = 0; b < 80; b++) begin
            in_valid = 1'b1; in_byte = 8'($urandom());
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(synd != '0, "R9 partial word nonzero", 32'(synd[31:0]), 1);
        do_start(1, 1);
        check(synd == '0, "R2 start clears", 32'(synd[31:0]), 0);
        check(no_err == 1'b1, "R2 no_err after clear", 32'(no_err), 1);
        make_gen(8);
        encode(nb);
        inject(nb, 5);
        calc_ref(8, nb);
        send_word(nb, 1'b0);
        check_syn("R9 R2 restarted syndromes");
        check(no_err == 1'b0, "R9 no_err", 32'(no_err), 0);
        done_low_next();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_clean(0, 0);
        test_clean(7, 3);
        test_clean(2, 1);
        test_errors(1, 0, 1, 1'b0);
        test_errors(3, 2, 15, 1'b0);
        test_errors(4, 1, 9, 1'b0);
        test_errors(5, 1, 18, 1'b0);
        test_errors(0, 2, 3, 1'b1);
        test_hold();
        test_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule